// File: doc/BRIEF.md
# Receive Byte Queue with Fill-Level and Idle-Watchdog Interrupt

This block is the receive-side byte queue of one serial channel. A deserializer pushes bytes in on one side and a host pops them on the other. The usable capacity can be switched between a shallow setting of 8 bytes and a deep setting of 256 bytes. The storage is a single 256-entry array. The smaller capacity only caps how many bytes may be held at once.

The host is interrupted in two ways. The first is a fill-level condition: the number of bytes held is compared with a threshold picked by a two-bit code, and the thresholds depend on the selected capacity. The second is an optional idle watchdog. It raises the interrupt when bytes have been held without any push or pop for 64 ticks of the receiver's 1X bit clock. This covers the case where a message ends with too few bytes to reach the fill threshold. All configuration inputs act at once, even while traffic is flowing.

Top module: `rx_fifo_wdog`

## Requirements
- R1: After a synchronous reset the queue holds no bytes: `empty`=1, `full`=0, `irq`=0, `overrun`=0.
- R2: Bytes come out in the order they went in. A pop accepted at a clock edge presents its byte on `rd_data` after that edge.
- R3: With `deep_sel`=0 the capacity is 8 bytes; with `deep_sel`=1 it is 256. `full` is high when the bytes held reach the capacity. A push while `full` is discarded and sets `overrun`, which stays high until reset.
- R4: With `deep_sel`=0, threshold codes 0, 1, 2 and 3 raise `irq` at 1 or more, 3 or more, 6 or more, and 8 bytes held.
- R5: With `deep_sel`=1, threshold codes 0, 1, 2 and 3 raise `irq` at 1 or more, 128 or more, 192 or more, and 256 bytes held.
- R6: The threshold code is {`lvl_hi`, `lvl_lo`}, with `lvl_hi` as bit 1. A change of code or capacity alters `irq` and `full` in the same cycle, with no clock edge needed.
- R7: With `wdog_en`=1 and bytes held, the 64th `bit_tick` with no push or pop sets a watchdog flag. The flag drives `irq` high and keeps it high until the next push or pop.
- R8: A push or pop strobe, accepted or not, restarts the idle count and clears the flag; a strobe in the same cycle as the 64th tick wins. An empty queue, or `wdog_en`=0, never sets the flag, and ticks in those states are not counted.
- R9: Changing `deep_sel` while bytes are held keeps the held count and the byte order. If the new capacity is at or below the count, `full` goes high.
- R10: A pop while empty has no effect: `empty` stays 1 and `rd_data` keeps its value. A push and a pop in the same cycle on a queue that is neither empty nor full leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Push strobe from the deserializer |
| wr_data | input | 8 | Byte to push |
| rd_en | input | 1 | Pop strobe from the host |
| rd_data | output | 8 | Byte popped, registered |
| bit_tick | input | 1 | One-cycle pulse per receiver 1X bit time |
| deep_sel | input | 1 | Capacity select: 0 = 8 bytes, 1 = 256 bytes |
| lvl_hi | input | 1 | Threshold code bit 1 |
| lvl_lo | input | 1 | Threshold code bit 0 |
| wdog_en | input | 1 | Idle watchdog enable |
| irq | output | 1 | Fill threshold reached OR watchdog flag |
| empty | output | 1 | No bytes held |
| full | output | 1 | Bytes held have reached the selected capacity |
| overrun | output | 1 | Sticky: a push was discarded while full |

## Verification
The idle watchdog's expiry and a queue access can fall in the same cycle. The bench provokes this by running 63 idle ticks and then raising `bit_tick` and `wr_en` together. It judges the result by requiring `irq` to stay low afterward and to rise only on the 64th tick counted from that push. A second collision, a push and a pop in the same cycle, is judged by the byte returned and by the order of the bytes read out afterward.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef enum logic [1:0] {
    LVL_ANY  = 2'b00,
    LVL_LOW  = 2'b01,
    LVL_MID  = 2'b10,
    LVL_FULL = 2'b11
  } lvl_code_e;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int ENTRIES = 1 << AW;

  logic [DW-1:0] mem [ENTRIES];

  // simple dual-port array with registered read for RAM inference
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxq_level.sv
module rxq_level
  import rxq_pkg::*;
#(
  parameter int DEEP    = 256,
  parameter int SHALLOW = 8,
  parameter int SH_LOW  = 3,
  parameter int SH_MID  = 6,
  localparam int AW = $clog2(DEEP),
  localparam int CW = $clog2(DEEP + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic          deep_sel,
  input  lvl_code_e     code,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [CW-1:0] fill,
  output logic          empty,
  output logic          full,
  output logic          lvl_hit,
  output logic          overrun
);
  localparam logic [CW-1:0] CAP_DEEP = CW'(DEEP);
  localparam logic [CW-1:0] CAP_SHAL = CW'(SHALLOW);
  localparam logic [CW-1:0] D_LOW    = CW'(DEEP / 2);
  localparam logic [CW-1:0] D_MID    = CW'((DEEP * 3) / 4);
  localparam logic [CW-1:0] S_LOW    = CW'(SH_LOW);
  localparam logic [CW-1:0] S_MID    = CW'(SH_MID);
  localparam logic [CW-1:0] ONE      = CW'(1);

  logic [CW-1:0] cap;
  logic [CW-1:0] thr;

  always_comb begin
    cap = deep_sel ? CAP_DEEP : CAP_SHAL;
    unique case (code)
      LVL_ANY:  thr = ONE;
      LVL_LOW:  thr = deep_sel ? D_LOW : S_LOW;
      LVL_MID:  thr = deep_sel ? D_MID : S_MID;
      default:  thr = cap;
    endcase
  end

  assign empty   = (fill == '0);
  assign full    = (fill >= cap);
  assign lvl_hit = (fill >= thr);
  assign push_ok = push_req && !full;
  assign pop_ok  = pop_req && !empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      fill    <= '0;
      wptr    <= '0;
      rptr    <= '0;
      overrun <= 1'b0;
    end else begin
      if (push_ok) wptr <= wptr + 1'b1;
      if (pop_ok)  rptr <= rptr + 1'b1;
      if (push_ok && !pop_ok)      fill <= fill + 1'b1;
      else if (pop_ok && !push_ok) fill <= fill - 1'b1;
      if (push_req && full) overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/rxq_wdog.sv
module rxq_wdog #(
  parameter int TICKS = 64,
  localparam int TW = (TICKS > 1) ? $clog2(TICKS) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tick,
  input  logic access,
  input  logic holding,
  output logic flag
);
  localparam logic [TW-1:0] LAST = TW'(TICKS - 1);

  logic [TW-1:0] idle_cnt;

  always_ff @(posedge clk) begin
    if (rst || access || !en || !holding) begin
      idle_cnt <= '0;
      flag     <= 1'b0;
    end else if (tick && !flag) begin
      if (idle_cnt == LAST) begin
        flag     <= 1'b1;
        idle_cnt <= '0;
      end else begin
        idle_cnt <= idle_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rx_fifo_wdog.sv
module rx_fifo_wdog
  import rxq_pkg::*;
#(
  parameter int DW          = 8,
  parameter int DEEP        = 256,
  parameter int SHALLOW     = 8,
  parameter int SH_LOW      = 3,
  parameter int SH_MID      = 6,
  parameter int WDOG_TICKS  = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic          bit_tick,
  input  logic          deep_sel,
  input  logic          lvl_hi,
  input  logic          lvl_lo,
  input  logic          wdog_en,
  output logic          irq,
  output logic          empty,
  output logic          full,
  output logic          overrun
);
  localparam int AW = $clog2(DEEP);
  localparam int CW = $clog2(DEEP + 1);

  logic          push_ok, pop_ok, lvl_hit, wdog_flag;
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] fill_cnt;
  lvl_code_e     code;

  assign code = lvl_code_e'({lvl_hi, lvl_lo});

  rxq_level #(
    .DEEP(DEEP), .SHALLOW(SHALLOW), .SH_LOW(SH_LOW), .SH_MID(SH_MID)
  ) u_level (
    .clk(clk), .rst(rst), .push_req(wr_en), .pop_req(rd_en),
    .deep_sel(deep_sel), .code(code), .push_ok(push_ok), .pop_ok(pop_ok),
    .wptr(wptr), .rptr(rptr), .fill(fill_cnt), .empty(empty), .full(full),
    .lvl_hit(lvl_hit), .overrun(overrun)
  );

  rxq_store #(.DW(DW), .AW(AW)) u_store (
    .clk(clk), .we(push_ok), .waddr(wptr), .wdata(wr_data),
    .re(pop_ok), .raddr(rptr), .rdata(rd_data)
  );

  rxq_wdog #(.TICKS(WDOG_TICKS)) u_wdog (
    .clk(clk), .rst(rst), .en(wdog_en), .tick(bit_tick),
    .access(wr_en || rd_en), .holding(!empty), .flag(wdog_flag)
  );

  assign irq = lvl_hit || wdog_flag;
endmodule

// File: rtl/rxq_check.sv
module rxq_check #(
  parameter int DEEP = 256,
  localparam int CW = $clog2(DEEP + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          rd_en,
  input logic          empty,
  input logic          full,
  input logic          overrun,
  input logic          irq,
  input logic          wdog_flag,
  input logic [CW-1:0] fill
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (empty && !full && !irq && !overrun));

  a_r3_full_drop: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && !rd_en) |=> $stable(fill));

  a_r3_overrun_set: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en) |=> overrun);

  a_r3_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  a_r3_fill_bound: assert property (@(posedge clk) disable iff (rst)
    fill <= CW'(DEEP));

  a_r7_flag_drives_irq: assert property (@(posedge clk) disable iff (rst)
    wdog_flag |-> irq);

  a_r8_access_clears: assert property (@(posedge clk) disable iff (rst)
    (wr_en || rd_en) |=> !wdog_flag);

  a_r8_empty_no_flag: assert property (@(posedge clk) disable iff (rst)
    empty |-> !wdog_flag);

  a_r10_empty_pop: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_en && !wr_en) |=> empty);
endmodule

bind rx_fifo_wdog rxq_check #(.DEEP(DEEP)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .empty(empty),
  .full(full), .overrun(overrun), .irq(irq), .wdog_flag(wdog_flag),
  .fill(fill_cnt)
);

// File: tb/rx_fifo_wdog_bench.sv
module rx_fifo_wdog_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, bit_tick = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       deep_sel = 1'b0, lvl_hi = 1'b0, lvl_lo = 1'b0, wdog_en = 1'b0;
  logic       irq, empty, full, overrun;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rx_fifo_wdog u_rx_fifo_wdog (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .bit_tick(bit_tick), .deep_sel(deep_sel),
    .lvl_hi(lvl_hi), .lvl_lo(lvl_lo), .wdog_en(wdog_en), .irq(irq),
    .empty(empty), .full(full), .overrun(overrun)
  );

  // vector: [12] deep, [11:10] code, [9:1] bytes pushed, [0] expected irq
  localparam logic [12:0] VECS [15] = '{
    {1'b0, 2'd0, 9'd0,   1'b0}, {1'b0, 2'd0, 9'd1,   1'b1},
    {1'b0, 2'd1, 9'd2,   1'b0}, {1'b0, 2'd1, 9'd3,   1'b1},
    {1'b0, 2'd2, 9'd5,   1'b0}, {1'b0, 2'd2, 9'd6,   1'b1},
    {1'b0, 2'd3, 9'd7,   1'b0}, {1'b0, 2'd3, 9'd8,   1'b1},
    {1'b1, 2'd0, 9'd1,   1'b1}, {1'b1, 2'd1, 9'd127, 1'b0},
    {1'b1, 2'd1, 9'd128, 1'b1}, {1'b1, 2'd2, 9'd191, 1'b0},
    {1'b1, 2'd2, 9'd192, 1'b1}, {1'b1, 2'd3, 9'd255, 1'b0},
    {1'b1, 2'd3, 9'd256, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; bit_tick = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pop(output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_tick = 1'b1;
    end
    @(negedge clk); bit_tick = 1'b0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog timeout actual=%0d expected=%0d", 0, 1);
      summary();
    end
  end

  initial begin
    logic [7:0] d;
    // R1 reset state
    do_reset();
    chk("R1 empty", empty, 1); chk("R1 full", full, 0);
    chk("R1 irq", irq, 0);     chk("R1 overrun", overrun, 0);

    // threshold table: R4 (shallow), R5 (deep), R3 full
    foreach (VECS[v]) begin
      int n, cap;
      deep_sel = VECS[v][12];
      {lvl_hi, lvl_lo} = VECS[v][11:10];
      do_reset();
      n = int'(VECS[v][9:1]);
      cap = deep_sel ? 256 : 8;
      for (int i = 0; i < n; i++) push(8'(i));
      chk(deep_sel ? "R5 irq" : "R4 irq", irq, int'(VECS[v][0]));
      chk("R3 full", full, int'(n == cap));
      chk("R10 empty", empty, int'(n == 0));
    end

    // R2 order; R6 immediate code change
    deep_sel = 1'b0; lvl_hi = 1'b0; lvl_lo = 1'b1;
    do_reset();
    for (int i = 0; i < 5; i++) push(8'hA0 + 8'(i));
    chk("R6 code1 irq", irq, 1);
    @(negedge clk); lvl_hi = 1'b1; #1;
    chk("R6 code3 irq immediate", irq, 0);
    for (int i = 0; i < 5; i++) begin
      pop(d); chk("R2 order", d, 8'hA0 + i);
    end
    chk("R2 empty after drain", empty, 1);

    // R3 overrun in shallow mode
    do_reset();
    for (int i = 0; i < 9; i++) push(8'h50 + 8'(i));
    chk("R3 full", full, 1); chk("R3 overrun", overrun, 1);
    for (int i = 0; i < 8; i++) begin
      pop(d); chk("R3 kept bytes", d, 8'h50 + i);
    end
    chk("R3 dropped ninth", empty, 1);
    chk("R3 overrun sticky", overrun, 1);

    // R10 push+pop same cycle, pop on empty
    do_reset();
    push(8'h11); push(8'h22);
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h33; rd_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    chk("R10 same-cycle pop data", rd_data, 8'h11);
    pop(d); chk("R10 order", d, 8'h22);
    pop(d); chk("R10 order", d, 8'h33);
    chk("R10 count kept", empty, 1);
    pop(d);
    chk("R10 empty pop data", d, 8'h33);
    chk("R10 empty pop", empty, 1);
    chk("R10 no overrun", overrun, 0);

    // R7 watchdog timeout and hold
    lvl_hi = 1'b1; lvl_lo = 1'b1; wdog_en = 1'b1;
    do_reset();
    push(8'h77);
    ticks(63); chk("R7 before 64th tick", irq, 0);
    ticks(1);  chk("R7 64th tick", irq, 1);
    ticks(10); chk("R7 flag holds", irq, 1);
    pop(d);    chk("R7 cleared by pop", irq, 0);

    // R8 access on the 64th tick wins, then full window restarts
    push(8'h01);
    ticks(63);
    @(negedge clk); bit_tick = 1'b1; wr_en = 1'b1; wr_data = 8'h02;
    @(negedge clk); bit_tick = 1'b0; wr_en = 1'b0;
    chk("R8 access beats tick", irq, 0);
    ticks(63); chk("R8 restart 63", irq, 0);
    ticks(1);  chk("R8 restart 64", irq, 1);

    // R8 empty queue and disabled watchdog never flag
    do_reset();
    ticks(100); chk("R8 empty no flag", irq, 0);
    wdog_en = 1'b0;
    push(8'h05);
    ticks(70); chk("R8 disabled no flag", irq, 0);
    wdog_en = 1'b1;
    ticks(63); chk("R8 no count while disabled", irq, 0);
    ticks(1);  chk("R8 enabled 64", irq, 1);

    // R9 depth switch keeps data
    wdog_en = 1'b0; deep_sel = 1'b1;
    do_reset();
    for (int i = 0; i < 10; i++) push(8'h30 + 8'(i));
    chk("R9 deep not full", full, 0); chk("R9 deep irq", irq, 0);
    @(negedge clk); deep_sel = 1'b0; #1;
    chk("R9 shallow full", full, 1); chk("R9 shallow irq", irq, 1);
    push(8'hEE); chk("R9 overrun", overrun, 1);
    for (int i = 0; i < 10; i++) begin
      pop(d); chk("R9 order kept", d, 8'h30 + i);
    end
    chk("R9 drained", empty, 1);

    done = 1'b1;
    summary();
  end
endmodule